// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns segment:offset pairs into 20-bit physical addresses. It holds three 16-bit segment registers, one each for code, stack and data, together with an instruction pointer and a stack pointer. The physical address is the segment value shifted left by four bits plus a 16-bit offset. Any carry beyond bit 19 is discarded, so a segment base always falls on a 16-byte boundary and one segment spans at most 64 KiB.

The code address pairs the code segment with the instruction pointer. The stack address pairs the stack segment with the stack pointer. The data address pairs the data segment with a displacement that the instruction supplies on an input.

Each cycle a request can pick one of the three addresses. The result appears one cycle later on a registered output, flagged by a valid bit. The consumer has no ready signal: the block never stalls, and an address is shown for exactly one cycle with valid high. Pointer stepping and segment writes run independently of the request qualifier.

Top module: `seg_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears all three segment registers, both pointers, `addr_out` and `addr_valid` to zero.
- R2: A physical address equals (segment × 16 + offset), taken in 20 bits. Code segment 0x2104 with instruction pointer 0x0042 gives 0x21082.
- R3: `sel` encodes 0 = code, 1 = stack and 2 = data. A request with `req_valid` high and `sel` in 0..2 places its address on `addr_out` with `addr_valid` high after exactly one clock edge.
- R4: When `req_valid` is low or `sel` is 3, `addr_valid` is low in the following cycle and `addr_out` keeps its previous value.
- R5: When `ip_step` is high, the instruction pointer grows by `ip_len` and wraps within 16 bits (0xFFFF + 3 gives 0x0002) without changing the code segment. When `ip_step` is low, the instruction pointer is unchanged. A code request in the same cycle uses the pointer value from before the step.
- R6: A push first lowers the stack pointer by 2, and the stack address of that cycle uses the lowered value. From zero, this gives 0xFFFE.
- R7: A pop forms the stack address from the current stack pointer and then raises the pointer by 2, wrapping within 16 bits.
- R8: When push and pop are high together, only the push acts.
- R9: A segment write takes effect at the clock edge. An address formed in the same cycle as the write uses the old segment value.
- R10: The carry out of bit 19 is dropped. Segment 0xFFFF with offset 0x0020 gives 0x00010.
- R11: The data address uses the data segment and the `disp` input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_we | input | 1 | Code segment write enable |
| cs_wdata | input | 16 | Code segment write value |
| ss_we | input | 1 | Stack segment write enable |
| ss_wdata | input | 16 | Stack segment write value |
| ds_we | input | 1 | Data segment write enable |
| ds_wdata | input | 16 | Data segment write value |
| ip_step | input | 1 | Advance the instruction pointer |
| ip_len | input | 4 | Instruction length in bytes |
| push | input | 1 | Stack push (pre-decrement by 2) |
| pop | input | 1 | Stack pop (post-increment by 2) |
| disp | input | 16 | Data displacement from the instruction |
| req_valid | input | 1 | Address request qualifier |
| sel | input | 2 | Address select: 0 code, 1 stack, 2 data, 3 none |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | High for one cycle when addr_out carries a new address |

## Verification
The code path is tried with a pointer built up through several instruction lengths, ending on the 0x2104:0x0042 pair. This separates a shift-and-add from a plain concatenation or an unshifted sum. The stack path runs through push, pop, push-with-pop and a pop that wraps the pointer to zero, which tells pre-decrement apart from post-increment and shows the push priority. The data path uses segment 0xFFFF with displacements that do and do not cross 2^20, which exposes a kept carry. Segment writes share a cycle with requests that use them, and a long run of steps carries the instruction pointer over 0xFFFF, so old-value reads and 16-bit offset wrap are both seen at the output.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W = 16;
  localparam int OFF_W = 16;
  localparam int SHIFT = 4;
  localparam int PA_W  = 20;
  localparam int LEN_W = 4;
  localparam int NSEG  = 3;

  typedef enum logic [1:0] {
    SEL_CODE  = 2'd0,
    SEL_STACK = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } addr_sel_e;

  localparam int IDX_CODE  = 0;
  localparam int IDX_STACK = 1;
  localparam int IDX_DATA  = 2;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSEG-1:0]            we,
  input  logic [NSEG-1:0][SEG_W-1:0] wdata,
  output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_q[g] <= '0;
      else if (we[g]) seg_q[g] <= wdata[g];
    end

    // R9: an unwritten segment register keeps its value
    p_seg_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(seg_q[g]));
    // R9: a write lands at the edge
    p_seg_load_r9: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> seg_q[g] == $past(wdata[g]));
  end
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit #(
  parameter int OFF_W = 16,
  parameter int LEN_W = 4,
  parameter int STACK_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ip_step,
  input  logic [LEN_W-1:0] ip_len,
  input  logic             push,
  input  logic             pop,
  output logic [OFF_W-1:0] ip_q,
  output logic [OFF_W-1:0] sp_eff
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STACK_STEP);

  logic [OFF_W-1:0] sp_q;
  logic [OFF_W-1:0] sp_dec;
  logic [OFF_W-1:0] sp_inc;
  logic [OFF_W-1:0] ip_next;

  assign sp_dec  = sp_q - STEP_V;
  assign sp_inc  = sp_q + STEP_V;
  assign ip_next = ip_q + OFF_W'(ip_len);

  // push takes priority; address uses lowered pointer on push, current otherwise
  assign sp_eff = push ? sp_dec : sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q <= '0;
      sp_q <= '0;
    end else begin
      if (ip_step) ip_q <= ip_next;
      if (push) sp_q <= sp_dec;
      else if (pop) sp_q <= sp_inc;
    end
  end

  p_ip_step_r5: assert property (@(posedge clk) disable iff (rst)
    ip_step |=> ip_q == OFF_W'($past(ip_q) + OFF_W'($past(ip_len))));
  p_ip_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ip_step |=> $stable(ip_q));
  p_push_dec_r6: assert property (@(posedge clk) disable iff (rst)
    push |=> sp_q == OFF_W'($past(sp_q) - STEP_V));
  p_pop_inc_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> sp_q == OFF_W'($past(sp_q) + STEP_V));
  p_sp_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!pop && !push) |=> $stable(sp_q));
endmodule

// File: rtl/addr_form.sv
module addr_form #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  localparam int BASE_W = SEG_W + SHIFT;
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

  logic [SUM_W-1:0] base_ext;
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  assign base_ext = SUM_W'({seg, {SHIFT{1'b0}}});
  assign off_ext  = SUM_W'(off);
  assign sum      = base_ext + off_ext;
  assign pa       = sum[PA_W-1:0];   // R10: higher carry dropped

  // R2: the base has zero low bits, so the low nibble is the offset's
  always_comb begin
    p_low_bits_r2: assert (pa[SHIFT-1:0] == off[SHIFT-1:0]);
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_we,
  input  logic [SEG_W-1:0]  cs_wdata,
  input  logic              ss_we,
  input  logic [SEG_W-1:0]  ss_wdata,
  input  logic              ds_we,
  input  logic [SEG_W-1:0]  ds_wdata,
  input  logic              ip_step,
  input  logic [LEN_W-1:0]  ip_len,
  input  logic              push,
  input  logic              pop,
  input  logic [OFF_W-1:0]  disp,
  input  logic              req_valid,
  input  logic [1:0]        sel,
  output logic [PA_W-1:0]   addr_out,
  output logic              addr_valid
);
  logic [NSEG-1:0]            seg_we;
  logic [NSEG-1:0][SEG_W-1:0] seg_wd;
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [NSEG-1:0][OFF_W-1:0] offs;
  logic [NSEG-1:0][PA_W-1:0]  pas;
  logic [OFF_W-1:0]           ip_q;
  logic [OFF_W-1:0]           sp_eff;
  logic [PA_W-1:0]            pa_sel;
  logic                       fire;
  addr_sel_e                  sel_e;

  assign seg_we[IDX_CODE]  = cs_we;
  assign seg_we[IDX_STACK] = ss_we;
  assign seg_we[IDX_DATA]  = ds_we;
  assign seg_wd[IDX_CODE]  = cs_wdata;
  assign seg_wd[IDX_STACK] = ss_wdata;
  assign seg_wd[IDX_DATA]  = ds_wdata;

  seg_bank #(.SEG_W(SEG_W), .NSEG(NSEG)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (seg_we),
    .wdata (seg_wd),
    .seg_q (seg_q)
  );

  ptr_unit #(.OFF_W(OFF_W), .LEN_W(LEN_W), .STACK_STEP(2)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .ip_step (ip_step),
    .ip_len  (ip_len),
    .push    (push),
    .pop     (pop),
    .ip_q    (ip_q),
    .sp_eff  (sp_eff)
  );

  assign offs[IDX_CODE]  = ip_q;
  assign offs[IDX_STACK] = sp_eff;
  assign offs[IDX_DATA]  = disp;

  for (genvar g = 0; g < NSEG; g++) begin : g_form
    addr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_form (
      .seg (seg_q[g]),
      .off (offs[g]),
      .pa  (pas[g])
    );
  end

  assign sel_e = addr_sel_e'(sel);
  assign fire  = req_valid && (sel_e != SEL_NONE);

  always_comb begin
    unique case (sel_e)
      SEL_CODE:  pa_sel = pas[IDX_CODE];
      SEL_STACK: pa_sel = pas[IDX_STACK];
      SEL_DATA:  pa_sel = pas[IDX_DATA];
      default:   pa_sel = addr_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= fire;
      if (fire) addr_out <= pa_sel;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && !addr_valid));
  p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sel != 2'd3) |=> addr_valid);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && sel != 2'd3) |=> (!addr_valid && $stable(addr_out)));
endmodule

// File: tb/seg_addr_unit_tb.sv
`timescale 1ns/1ps
module seg_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_we, ss_we, ds_we;
  logic [15:0] cs_wdata, ss_wdata, ds_wdata;
  logic        ip_step;
  logic [3:0]  ip_len;
  logic        push, pop;
  logic [15:0] disp;
  logic        req_valid;
  logic [1:0]  sel;
  logic [19:0] addr_out;
  logic        addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_addr_unit u_dut (
    .clk(clk), .rst(rst),
    .cs_we(cs_we), .cs_wdata(cs_wdata),
    .ss_we(ss_we), .ss_wdata(ss_wdata),
    .ds_we(ds_we), .ds_wdata(ds_wdata),
    .ip_step(ip_step), .ip_len(ip_len),
    .push(push), .pop(pop), .disp(disp),
    .req_valid(req_valid), .sel(sel),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  // wr: 0 none, 1 code seg, 2 stack seg, 3 data seg
  typedef struct packed {
    logic [1:0]  wr;
    logic [15:0] wd;
    logic        st;
    logic [3:0]  len;
    logic        pu;
    logic        po;
    logic [15:0] dp;
    logic        rv;
    logic [1:0]  sl;
    logic        ev;
    logic [19:0] ea;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h2104, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h00000, 8'd9},  // R9 old CS
    '{2'd0, 16'h0000, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h21040, 8'd3},  // R3
    '{2'd0, 16'h0000, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h2104F, 8'd5},  // R5
    '{2'd0, 16'h0000, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 20'h2104F, 8'd4},  // R4 no request
    '{2'd0, 16'h0000, 1'b1, 4'd15, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd3, 1'b0, 20'h2104F, 8'd4},  // R4 sel 3
    '{2'd0, 16'h0000, 1'b1, 4'd6,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h2107C, 8'd5},  // R5
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h21082, 8'd2},  // R2 example
    '{2'd2, 16'h3000, 1'b0, 4'd0,  1'b1, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h0FFFE, 8'd6},  // R6 from zero, old SS
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b1, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h3FFFC, 8'd6},  // R6
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b1, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h3FFFC, 8'd7},  // R7
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b1, 1'b1, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h3FFFC, 8'd8},  // R8 push wins
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b1, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h3FFFC, 8'd8},  // R8 follow-up
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b1, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h3FFFE, 8'd7},  // R7
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd1, 1'b1, 20'h30000, 8'd7},  // R7 wrap to 0
    '{2'd3, 16'hFFFF, 1'b0, 4'd0,  1'b0, 1'b0, 16'h1234, 1'b1, 2'd2, 1'b1, 20'h01234, 8'd11}, // R11 old DS
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0020, 1'b1, 2'd2, 1'b1, 20'h00010, 8'd10}, // R10
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b0, 16'h000F, 1'b1, 2'd2, 1'b1, 20'hFFFFF, 8'd11}, // R11
    '{2'd1, 16'hFFFF, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd2, 1'b1, 20'hFFFF0, 8'd11}, // R11
    '{2'd0, 16'h0000, 1'b0, 4'd0,  1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 1'b1, 20'h00032, 8'd10}  // R10 code wrap
  };

  task automatic idle_inputs();
    cs_we = 0; ss_we = 0; ds_we = 0;
    cs_wdata = '0; ss_wdata = '0; ds_wdata = '0;
    ip_step = 0; ip_len = '0; push = 0; pop = 0;
    disp = '0; req_valid = 0; sel = '0;
  endtask

  task automatic check(input string tag, input logic ev, input logic [19:0] ea);
    checks++;
    if (addr_valid !== ev || addr_out !== ea) begin
      errors++;
      $display("FAIL %s: got valid=%0b addr=%05h, expected valid=%0b addr=%05h",
               tag, addr_valid, addr_out, ev, ea);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset", 1'b0, 20'h00000);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      cs_we = (VECS[i].wr == 2'd1); cs_wdata = VECS[i].wd;
      ss_we = (VECS[i].wr == 2'd2); ss_wdata = VECS[i].wd;
      ds_we = (VECS[i].wr == 2'd3); ds_wdata = VECS[i].wd;
      ip_step = VECS[i].st; ip_len = VECS[i].len;
      push = VECS[i].pu; pop = VECS[i].po; disp = VECS[i].dp;
      req_valid = VECS[i].rv; sel = VECS[i].sl;
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ev, VECS[i].ea);
    end

    // R1: reset in mid-run clears output and all state
    @(negedge clk); idle_inputs(); rst = 1'b1; req_valid = 1; sel = 2'd0;
    @(posedge clk); #1;
    check("R1 mid-run reset", 1'b0, 20'h00000);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 pointers and segments cleared", 1'b1, 20'h00000);

    // R5: instruction pointer wraps within 16 bits, code segment untouched
    @(negedge clk); idle_inputs(); cs_we = 1; cs_wdata = 16'h1000;
    @(negedge clk); idle_inputs(); ip_step = 1; ip_len = 4'd15;
    repeat (4369) @(negedge clk);
    ip_len = 4'd3; req_valid = 1; sel = 2'd0;
    @(posedge clk); #1;
    check("R5 pointer at 0xFFFF", 1'b1, 20'h1FFFF);
    @(negedge clk); idle_inputs(); req_valid = 1; sel = 2'd0;
    @(posedge clk); #1;
    check("R5 pointer wrapped to 0x0002", 1'b1, 20'h10002);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    check("R4 idle after request", 1'b0, 20'h10002);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule